// File: doc/BRIEF.md
# Shared ADC Channel Scheduler

This block owns a single analog-to-digital converter that three inputs share. Channel 0 carries a fast signal-amplitude measurement and is normally converted back to back: as soon as one conversion finishes, the next one on channel 0 begins, and each result leaves with a one-cycle strobe. Two slow inputs sit beside it. Channel 1 is an ambient light sensor and channel 2 is a potentiometer. Each has its own fixed period, counted in ticks of an external time base. With a 5 ms tick, the defaults give 1.28 s for the light sensor and 250 ms for the potentiometer.

When a slow channel falls due, the scheduler does not cut short the conversion in flight. At the next conversion boundary it drops continuous sampling of channel 0 and issues a single conversion on the slow channel. It waits for that result, latches it with a strobe, and then returns to continuous sampling on channel 0. If both slow channels are due together, the potentiometer goes first and the light sensor follows straight after.

The converter handshake is a one-cycle start pulse with a channel select. The converter answers some cycles later with a one-cycle done pulse and the data.

Top module: `adc_sched`

## Requirements
- R1: A synchronous active-high reset clears all three stored results to zero, drops every valid strobe and the start pulse, and forgets any pending slow-channel request.
- R2: After reset the first conversion started is on channel 0 (channel code 0 = amplitude). Each completed conversion is followed by the next start exactly one cycle after its valid strobe. A channel 0 completion raises amp_valid for one cycle with amp_data equal to the converter data.
- R3: The potentiometer (channel code 2) is converted once for every POT_TICKS ticks, triggered by the tick that completes each period.
- R4: The light sensor (channel code 1) is converted once for every LIGHT_TICKS ticks, triggered by the tick that completes each period.
- R5: No start is issued while a conversion is outstanding, and conv_chan stays unchanged until that conversion's done is seen.
- R6: A slow-channel result is latched into its own output with a valid pulse exactly one cycle long. The output then holds that value until the next conversion on the same channel. At most one valid strobe is high in any cycle.
- R7: After a slow-channel conversion completes with no other slow request pending, the next start is on channel 0.
- R8: When both periods expire on the same tick, the potentiometer is started before the light sensor. The light sensor start follows with no channel 0 conversion between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | One-cycle time-base pulse (nominally every 5 ms) |
| conv_start | output | 1 | One-cycle request to begin a conversion |
| conv_chan | output | 2 | Channel for the conversion: 0 amplitude, 1 light, 2 potentiometer |
| conv_done | input | 1 | One-cycle pulse from the converter: result ready |
| conv_data | input | DW | Conversion result, valid with conv_done |
| amp_data | output | DW | Latest amplitude result |
| amp_valid | output | 1 | One-cycle strobe for a new amplitude result |
| light_data | output | DW | Latest light sensor result |
| light_valid | output | 1 | One-cycle strobe for a new light result |
| pot_data | output | DW | Latest potentiometer result |
| pot_valid | output | 1 | One-cycle strobe for a new potentiometer result |

## Verification
The bench builds the block with LIGHT_TICKS = 8 and POT_TICKS = 3, so both periods expire together on every 24th tick. In 48 ticks the bench sees sixteen potentiometer services, six light services and two coincidences. The converter model varies its latency from conversion to conversion, and ticks arrive while channel 0 conversions are in flight. Pre-emption is therefore tested only at conversion boundaries, as intended. The bench logs the start order, stamped with tick counts, and checks it against the periods, the pot-before-light rule and the return to channel 0.

// File: rtl/adc_sched.sv
module adc_sched #(
  parameter int DW          = 10,
  parameter int LIGHT_TICKS = 256,
  parameter int POT_TICKS   = 50
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  output logic          conv_start,
  output logic [1:0]    conv_chan,
  input  logic          conv_done,
  input  logic [DW-1:0] conv_data,
  output logic [DW-1:0] amp_data,
  output logic          amp_valid,
  output logic [DW-1:0] light_data,
  output logic          light_valid,
  output logic [DW-1:0] pot_data,
  output logic          pot_valid
);
  localparam int LW = (LIGHT_TICKS > 1) ? $clog2(LIGHT_TICKS) : 1;
  localparam int PW = (POT_TICKS > 1) ? $clog2(POT_TICKS) : 1;
  localparam logic [1:0] CH_AMP = 2'd0, CH_LIGHT = 2'd1, CH_POT = 2'd2;

  logic          busy, start_q, pend_l, pend_p;
  logic [1:0]    chan_q, next_chan;
  logic [LW-1:0] lcnt;
  logic [PW-1:0] pcnt;

  wire l_due   = tick && (lcnt == LW'(LIGHT_TICKS - 1));
  wire p_due   = tick && (pcnt == PW'(POT_TICKS - 1));
  wire done_ok = busy && conv_done;

  assign next_chan  = pend_p ? CH_POT : (pend_l ? CH_LIGHT : CH_AMP);
  assign conv_start = start_q;
  assign conv_chan  = chan_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy        <= 1'b0;
      start_q     <= 1'b0;
      pend_l      <= 1'b0;
      pend_p      <= 1'b0;
      chan_q      <= CH_AMP;
      lcnt        <= '0;
      pcnt        <= '0;
      amp_data    <= '0;
      light_data  <= '0;
      pot_data    <= '0;
      amp_valid   <= 1'b0;
      light_valid <= 1'b0;
      pot_valid   <= 1'b0;
    end else begin
      start_q     <= 1'b0;
      amp_valid   <= 1'b0;
      light_valid <= 1'b0;
      pot_valid   <= 1'b0;

      if (tick) begin
        lcnt <= l_due ? '0 : lcnt + 1'b1;
        pcnt <= p_due ? '0 : pcnt + 1'b1;
      end

      if (done_ok) begin
        busy <= 1'b0;
        case (chan_q)
          CH_LIGHT: begin light_data <= conv_data; light_valid <= 1'b1; end
          CH_POT:   begin pot_data   <= conv_data; pot_valid   <= 1'b1; end
          default:  begin amp_data   <= conv_data; amp_valid   <= 1'b1; end
        endcase
      end

      if (!busy) begin
        busy    <= 1'b1;
        start_q <= 1'b1;
        chan_q  <= next_chan;
        if (next_chan == CH_POT)   pend_p <= 1'b0;
        if (next_chan == CH_LIGHT) pend_l <= 1'b0;
      end

      if (l_due) pend_l <= 1'b1;
      if (p_due) pend_p <= 1'b1;
    end
  end

  p_no_start_busy_r5: assert property (@(posedge clk) disable iff (rst)
    (busy && !conv_done) |=> !conv_start);

  p_chan_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (busy && !conv_done) |=> $stable(conv_chan));

  p_one_valid_r6: assert property (@(posedge clk) disable iff (rst)
    $onehot0({amp_valid, light_valid, pot_valid}));

  p_pot_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    pot_valid |=> !pot_valid);

  p_light_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    light_valid |=> !light_valid);

  p_resume_r7: assert property (@(posedge clk) disable iff (rst)
    (light_valid && !pend_p && !pend_l && !tick) |=> (conv_start && conv_chan == CH_AMP));

  p_order_r8: assert property (@(posedge clk) disable iff (rst)
    (conv_start && conv_chan == CH_LIGHT) |-> !$past(pend_p));
endmodule

// File: tb/sim_adc_sched.sv
module sim_adc_sched;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 10;
  localparam int LT = 8;
  localparam int PT = 3;
  localparam int NTICKS = 48;
  localparam int TICK_GAP = 40;

  logic clk = 1'b0, rst = 1'b1, tick = 1'b0, conv_done = 1'b0;
  logic [DW-1:0] conv_data = '0;
  logic conv_start, amp_valid, light_valid, pot_valid;
  logic [1:0] conv_chan;
  logic [DW-1:0] amp_data, light_data, pot_data;

  adc_sched #(.DW(DW), .LIGHT_TICKS(LT), .POT_TICKS(PT)) u0 (
    .clk(clk), .rst(rst), .tick(tick), .conv_start(conv_start), .conv_chan(conv_chan),
    .conv_done(conv_done), .conv_data(conv_data), .amp_data(amp_data), .amp_valid(amp_valid),
    .light_data(light_data), .light_valid(light_valid), .pot_data(pot_data), .pot_valid(pot_valid));

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0;
  typedef struct { int ch; int d; } item_t;
  item_t expq[$];
  int start_ch[$];
  int start_tk[$];
  int tcount = 0;
  bit tick_en = 0, log_en = 0;
  int last_light = 0, last_pot = 0;

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // time base
  initial forever begin
    repeat (TICK_GAP) @(negedge clk);
    if (tick_en) tick <= 1'b1;
    @(negedge clk);
    tick <= 1'b0;
  end

  // converter model and driver: pushes the expected result of each conversion
  initial begin
    bit outstanding = 0, started = 0, prev_valid = 0;
    int countdown = 0, cur = 0, seq = 0;
    forever begin
      @(negedge clk);
      conv_done = 1'b0;
      if (rst) begin
        outstanding = 0; started = 0; countdown = 0; prev_valid = 0;
      end else begin
        if (countdown > 0) begin
          countdown--;
          if (countdown == 0) begin
            item_t it;
            it.ch = cur; it.d = (cur << 8) | (seq & 8'hff);
            conv_data = DW'(it.d);
            conv_done = 1'b1;
            expq.push_back(it);
            outstanding = 0;
            seq++;
          end
        end
        if (conv_start) begin
          check(!outstanding, "R5", "start while outstanding", 1, 0);
          if (!started) check(conv_chan == 2'd0, "R2", "first channel after reset", int'(conv_chan), 0);
          else check(prev_valid, "R2", "start one cycle after valid", int'(prev_valid), 1);
          started = 1;
          outstanding = 1;
          cur = int'(conv_chan);
          countdown = 3 + seq % 5;
          if (log_en) begin start_ch.push_back(cur); start_tk.push_back(tcount); end
        end
        if (tick) tcount++;
        prev_valid = amp_valid | light_valid | pot_valid;
      end
    end
  end

  // monitor: pops and compares as the design produces results
  initial forever begin
    @(negedge clk);
    if (!rst && (amp_valid | light_valid | pot_valid)) begin
      int ch;
      int d;
      ch = pot_valid ? 2 : (light_valid ? 1 : 0);
      d  = pot_valid ? int'(pot_data) : (light_valid ? int'(light_data) : int'(amp_data));
      if (expq.size() == 0) check(0, "R6", "valid with no conversion", ch, -1);
      else begin
        item_t e;
        e = expq.pop_front();
        check(ch == e.ch, (ch == 0) ? "R2" : "R6", "result channel", ch, e.ch);
        check(d == e.d, (ch == 0) ? "R2" : "R6", "result data", d, e.d);
        if (ch == 1) last_light = d;
        if (ch == 2) last_pot = d;
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    check(0, "R2", "watchdog expired", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int npot, nlight;
    repeat (3) @(negedge clk);
    check(!conv_start, "R1", "start in reset", int'(conv_start), 0);
    check(!(amp_valid | light_valid | pot_valid), "R1", "valid in reset", 1, 0);
    check(amp_data == 0 && light_data == 0 && pot_data == 0, "R1", "results in reset",
          int'(amp_data | light_data | pot_data), 0);
    rst <= 1'b0;
    tick_en <= 1'b1;
    log_en <= 1'b1;
    wait (tcount == NTICKS);
    tick_en <= 1'b0;
    repeat (60) @(negedge clk);
    log_en <= 1'b0;
    @(negedge clk);

    npot = 0; nlight = 0;
    for (int i = 0; i < start_ch.size(); i++) begin
      if (start_ch[i] == 2) begin
        npot++;
        check(start_tk[i] % PT == 0 && start_tk[i] == npot * PT, "R3", "pot service tick", start_tk[i], npot * PT);
      end
      if (start_ch[i] == 1) begin
        nlight++;
        check(start_tk[i] == nlight * LT, "R4", "light service tick", start_tk[i], nlight * LT);
        if (start_tk[i] % (LT * PT) == 0)
          check(i > 0 && start_ch[i-1] == 2 && start_tk[i-1] == start_tk[i], "R8",
                "pot before light on shared tick", (i > 0) ? start_ch[i-1] : -1, 2);
      end
      if (start_ch[i] != 0 && i + 1 < start_ch.size()) begin
        if (start_ch[i] == 1 || start_tk[i] % LT != 0)
          check(start_ch[i+1] == 0, "R7", "resume on channel 0", start_ch[i+1], 0);
      end
    end
    check(npot == NTICKS / PT, "R3", "pot service count", npot, NTICKS / PT);
    check(nlight == NTICKS / LT, "R4", "light service count", nlight, NTICKS / LT);
    check(int'(light_data) == last_light, "R6", "light result held", int'(light_data), last_light);
    check(int'(pot_data) == last_pot, "R6", "pot result held", int'(pot_data), last_pot);
    check(expq.size() <= 1, "R5", "completed conversions left unreported", expq.size(), 0);

    rst <= 1'b1;
    repeat (3) @(negedge clk);
    check(amp_data == 0 && light_data == 0 && pot_data == 0, "R1", "results cleared by reset",
          int'(amp_data | light_data | pot_data), 0);
    check(!(amp_valid | light_valid | pot_valid), "R1", "valids cleared by reset", 1, 0);
    check(!conv_start, "R1", "start cleared by reset", int'(conv_start), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule